// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block tracks every in-flight load between allocation and retirement, so that loads may take cache data out of program order. A load may hit in the cache while an older load is still waiting on a miss. The core allocates one entry per load in program order. When the load receives its data, it reports that completion together with its address, and the entry keeps the line address. Each invalidation or eviction seen on the coherence side is broadcast as a snoop. The snoop is compared in one cycle against every completed, unretired entry.

A completed entry whose line is snooped away while some older load is still waiting for data has broken the assumption that its early data would stay valid until program order allowed the read. Such an entry is marked. When the marked load reaches the head of the queue and the core asks to retire it, the block refuses the retirement and raises a flush request carrying that entry's index. Every entry from that index to the tail is then dropped, and a saturating event counter increments. A load can only retire once its own data has arrived.

Top module: `load_order_guard`

## Requirements
- R1: Entries are allocated in program order. `alloc_idx` shows the slot the next load receives, and after each accepted allocation it advances by one modulo DEPTH. `alloc_ready` is low while DEPTH entries are held, and an allocation request made then changes nothing.
- R2: `retire_grant` is high only when `retire_req` is high and the oldest entry is valid, has completed and is unmarked. A granted retirement frees that entry.
- R3: A snoop matches an entry when bits ADDR_W-1 down to LINE_OFF of `snoop_addr` equal the same bits of the address given at that entry's completion. The offset bits below LINE_OFF are ignored. Only valid, completed entries can match.
- R4: A matching entry is marked only if some older valid entry has not completed. Completion state is taken as it stood at the start of the snoop cycle, so an older load completing in that same cycle still counts as outstanding.
- R5: A snoop that matches nothing, or that hits an entry with no outstanding older load, has no effect: the load later retires normally.
- R6: When `retire_req` meets a marked oldest entry, `flush_valid` is high, `flush_idx` equals that entry's index and `retire_grant` is low. On the next cycle the queue is empty and `alloc_idx` equals the flushed index.
- R7: `flush_count` increases by one for each flush and holds at its all-ones value.
- R8: `alloc_ready` is low in a cycle where `flush_valid` is high.
- R9: After reset the queue is empty, `alloc_ready` is 1, `alloc_idx` is 0, `flush_count` is 0, and no retirement is granted.
- R10: A completion report for an index that holds no allocated load is ignored: the load later allocated to that slot still counts as not completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a new entry for the next load in program order |
| alloc_ready | output | 1 | Queue can accept an allocation this cycle |
| alloc_idx | output | $clog2(DEPTH) | Index the next allocation receives |
| done_valid | input | 1 | A load has received its data |
| done_idx | input | $clog2(DEPTH) | Entry of the completing load |
| done_addr | input | ADDR_W | Address read by the completing load |
| snoop_valid | input | 1 | Invalidation or eviction from the coherence side |
| snoop_addr | input | ADDR_W | Address of the line being lost |
| retire_req | input | 1 | Core wants to retire the oldest load |
| retire_grant | output | 1 | Oldest load retires this cycle |
| flush_valid | output | 1 | Memory-order mis-speculation flush request |
| flush_idx | output | $clog2(DEPTH) | Entry from which the pipeline must restart |
| flush_count | output | CNT_W | Number of flushes raised (saturating) |

## Verification
Assertions check the following on every cycle: the occupancy never exceeds the depth, a mark only ever sits on a valid completed entry, a granted retirement lowers occupancy by one, a flush leaves the queue empty, and the event counter moves by exactly one step per flush. The age-dependent choice of whether a snoop marks a load can only be shown by the bench's scenarios. These include different patterns of outstanding older loads, offsets inside the line, mismatching lines and completions in the same cycle as the snoop. Pointer wrap, a full queue and counter saturation are also reached only through those scenarios.

// File: rtl/lqg_pkg.sv
package lqg_pkg;
   typedef enum logic {
      CTR_WRAP = 1'b0,
      CTR_SAT  = 1'b1
   } ctr_mode_e;
endpackage

// File: rtl/lqg_ring_ptr.sv
module lqg_ring_ptr #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   input  logic [IDX_W-1:0] flush_idx,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [OCC_W-1:0] occ
);
   initial begin : p_elab
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two, at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else if (flush) begin
         // everything from the flushed slot onward is dropped
         tail <= flush_idx;
         occ  <= '0;
      end else begin
         if (push) tail <= tail + IDX_W'(1);
         if (pop)  head <= head + IDX_W'(1);
         occ <= occ + OCC_W'(push) - OCC_W'(pop);
      end
   end

   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(DEPTH));
   a_r1_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> occ < OCC_W'(DEPTH));
endmodule

// File: rtl/lqg_age_scan.sv
module lqg_age_scan #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0] head,
   input  logic [DEPTH-1:0] valid,
   input  logic [DEPTH-1:0] done,
   output logic [DEPTH-1:0] older_pend
);
   // Walk from the oldest slot: each slot sees whether any older slot
   // is still waiting for its data (R4).
   logic [IDX_W-1:0] pos;
   logic             pend;

   always_comb begin
      older_pend = '0;
      pend       = 1'b0;
      pos        = head;
      for (int k = 0; k < DEPTH; k++) begin
         pos             = head + IDX_W'(k);
         older_pend[pos] = pend;
         pend            = pend | (valid[pos] & ~done[pos]);
      end
   end
endmodule

// File: rtl/lqg_entry_array.sv
module lqg_entry_array #(
   parameter int DEPTH = 16,
   parameter int TAG_W = 26,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             alloc_fire,
   input  logic [IDX_W-1:0] alloc_slot,
   input  logic             retire_fire,
   input  logic [IDX_W-1:0] head,
   input  logic             done_valid,
   input  logic [IDX_W-1:0] done_idx,
   input  logic [TAG_W-1:0] done_tag,
   input  logic             snoop_valid,
   input  logic [TAG_W-1:0] snoop_tag,
   input  logic [DEPTH-1:0] older_pend,
   output logic [DEPTH-1:0] valid_q,
   output logic [DEPTH-1:0] done_q,
   output logic [DEPTH-1:0] mark_q
);
   initial begin : p_elab
      assert (TAG_W >= 1) else $fatal(1, "TAG_W must be positive");
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [TAG_W-1:0] tag_q;
      logic             hit;

      // compare uses state from the start of the cycle (R3, R4)
      assign hit = snoop_valid && valid_q[e] && done_q[e] &&
                   (tag_q == snoop_tag) && older_pend[e];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            done_q[e]  <= 1'b0;
            mark_q[e]  <= 1'b0;
            tag_q      <= '0;
         end else if (flush) begin
            valid_q[e] <= 1'b0;
            done_q[e]  <= 1'b0;
            mark_q[e]  <= 1'b0;
         end else if (alloc_fire && alloc_slot == IDX_W'(e)) begin
            valid_q[e] <= 1'b1;
            done_q[e]  <= 1'b0;
            mark_q[e]  <= 1'b0;
         end else begin
            if (retire_fire && head == IDX_W'(e)) begin
               valid_q[e] <= 1'b0;
               done_q[e]  <= 1'b0;
               mark_q[e]  <= 1'b0;
            end else begin
               // R10: completion of an unallocated slot is dropped
               if (done_valid && done_idx == IDX_W'(e) && valid_q[e] && !done_q[e]) begin
                  done_q[e] <= 1'b1;
                  tag_q     <= done_tag;
               end
               if (hit) mark_q[e] <= 1'b1;
            end
         end
      end

      a_r3_mark_on_done: assert property (@(posedge clk) disable iff (!rst_n)
         mark_q[e] |-> (valid_q[e] && done_q[e]));
      a_r4_mark_needs_older: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mark_q[e]) |-> $past(older_pend[e] && snoop_valid));
   end
endmodule

// File: rtl/lqg_evt_ctr.sv
module lqg_evt_ctr #(
   parameter int CNT_W = 16,
   parameter lqg_pkg::ctr_mode_e MODE = lqg_pkg::CTR_SAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] q
);
   initial begin : p_elab
      assert (CNT_W >= 1 && CNT_W <= 64) else $fatal(1, "CNT_W out of range");
   end

   if (MODE == lqg_pkg::CTR_SAT) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                 q <= '0;
         else if (inc && (q != '1))  q <= q + CNT_W'(1);
      end
      a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
         inc |=> (q == $past(q) + CNT_W'(1)) || ($past(q) == '1 && q == '1));
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   q <= '0;
         else if (inc) q <= q + CNT_W'(1);
      end
      a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
         inc |=> q == $past(q) + CNT_W'(1));
   end

   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(q));
endmodule

// File: rtl/load_order_guard.sv
module load_order_guard #(
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 32,
   parameter int LINE_OFF = 6,
   parameter int CNT_W    = 16,
   parameter lqg_pkg::ctr_mode_e CNT_MODE = lqg_pkg::CTR_SAT,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int TAG_W = ADDR_W - LINE_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_idx,
   input  logic              done_valid,
   input  logic [IDX_W-1:0]  done_idx,
   input  logic [ADDR_W-1:0] done_addr,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic              retire_req,
   output logic              retire_grant,
   output logic              flush_valid,
   output logic [IDX_W-1:0]  flush_idx,
   output logic [CNT_W-1:0]  flush_count
);
   localparam int OCC_W = $clog2(DEPTH + 1);

   initial begin : p_elab
      assert (LINE_OFF >= 0 && LINE_OFF < ADDR_W)
         else $fatal(1, "LINE_OFF must leave at least one tag bit");
   end

   logic [IDX_W-1:0] head, tail;
   logic [OCC_W-1:0] occ;
   logic [DEPTH-1:0] valid_q, done_q, mark_q, older_pend;
   logic             alloc_fire, head_ready;
   logic [TAG_W-1:0] done_tag, snoop_tag;
   logic             unused_offset_bits;

   // R3: only the line part of an address takes part in the compare
   assign done_tag  = done_addr[ADDR_W-1:LINE_OFF];
   assign snoop_tag = snoop_addr[ADDR_W-1:LINE_OFF];
   if (LINE_OFF > 0) begin : g_off
      assign unused_offset_bits = ^{done_addr[LINE_OFF-1:0], snoop_addr[LINE_OFF-1:0]};
   end else begin : g_nooff
      assign unused_offset_bits = 1'b0;
   end

   assign head_ready   = valid_q[head] && done_q[head];
   assign retire_grant = retire_req && head_ready && !mark_q[head];  // R2
   assign flush_valid  = retire_req && head_ready && mark_q[head];   // R6
   assign flush_idx    = head;
   assign alloc_ready  = (occ != OCC_W'(DEPTH)) && !flush_valid;     // R1, R8
   assign alloc_fire   = alloc_valid && alloc_ready;
   assign alloc_idx    = tail;

   lqg_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (alloc_fire),
      .pop       (retire_grant),
      .flush     (flush_valid),
      .flush_idx (flush_idx),
      .head      (head),
      .tail      (tail),
      .occ       (occ)
   );

   lqg_age_scan #(.DEPTH(DEPTH)) u_age (
      .head       (head),
      .valid      (valid_q),
      .done       (done_q),
      .older_pend (older_pend)
   );

   lqg_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush_valid),
      .alloc_fire  (alloc_fire),
      .alloc_slot  (tail),
      .retire_fire (retire_grant),
      .head        (head),
      .done_valid  (done_valid),
      .done_idx    (done_idx),
      .done_tag    (done_tag),
      .snoop_valid (snoop_valid),
      .snoop_tag   (snoop_tag),
      .older_pend  (older_pend),
      .valid_q     (valid_q),
      .done_q      (done_q),
      .mark_q      (mark_q)
   );

   lqg_evt_ctr #(.CNT_W(CNT_W), .MODE(CNT_MODE)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (flush_valid),
      .q     (flush_count)
   );

   a_r2_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_grant && !alloc_fire) |=> occ == $past(occ) - OCC_W'(1));
   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (occ == '0 && alloc_idx == $past(flush_idx)));
   a_r6_flush_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({retire_grant, flush_valid}));
endmodule

// File: tb/sim_load_order_guard.sv
module sim_load_order_guard;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int AW = 32;
   localparam int CW = 3;
   localparam int IW = $clog2(DEPTH);

   // row: [6] flush expected, [5] snoop hits the line, [4:3] target load,
   //      [2:0] bit k set = load k completed before the snoop
   localparam logic [6:0] ROWS [8] = '{
      7'b1110110, 7'b1101110, 7'b0110111, 7'b0101011,
      7'b1110101, 7'b1110100, 7'b0010110, 7'b0100110 };

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_valid = 0, done_valid = 0, snoop_valid = 0, retire_req = 0;
   logic [IW-1:0] done_idx = '0;
   logic [AW-1:0] done_addr = '0, snoop_addr = '0;
   logic alloc_ready, retire_grant, flush_valid;
   logic [IW-1:0] alloc_idx, flush_idx;
   logic [CW-1:0] flush_count;

   int nchk = 0, nerr = 0, exp_tail = 0, exp_cnt = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   load_order_guard #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_OFF(6), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
      .alloc_idx(alloc_idx), .done_valid(done_valid), .done_idx(done_idx),
      .done_addr(done_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .retire_req(retire_req), .retire_grant(retire_grant), .flush_valid(flush_valid),
      .flush_idx(flush_idx), .flush_count(flush_count));

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int sat(input int v);
      return (v > 7) ? 7 : v;
   endfunction

   task automatic do_alloc(output int idx);
      alloc_valid = 1;
      #1;
      chk(alloc_ready == 1, "R1 ready", alloc_ready, 1);
      chk(alloc_idx == IW'(exp_tail), "R1 alloc order", alloc_idx, exp_tail);
      idx = exp_tail;
      exp_tail = (exp_tail + 1) % DEPTH;
      @(negedge clk);
      alloc_valid = 0;
   endtask

   task automatic do_done(input int idx, input logic [AW-1:0] a);
      done_valid = 1; done_idx = IW'(idx); done_addr = a;
      @(negedge clk);
      done_valid = 0;
   endtask

   task automatic do_snoop(input logic [AW-1:0] a);
      snoop_valid = 1; snoop_addr = a;
      @(negedge clk);
      snoop_valid = 0;
   endtask

   task automatic do_retire(input bit want_flush, input int idx, input string req);
      retire_req = 1;
      #1;
      chk(flush_valid == want_flush, req, flush_valid, want_flush);
      chk(retire_grant == !want_flush, req, retire_grant, !want_flush);
      if (want_flush) begin
         chk(flush_idx == IW'(idx), "R6 flush index", flush_idx, idx);
         exp_tail = idx;
         exp_cnt++;
      end
      @(negedge clk);
      retire_req = 0;
      if (want_flush) begin
         chk(alloc_idx == IW'(idx), "R6 restart slot", alloc_idx, idx);
         chk(flush_count == CW'(sat(exp_cnt)), "R7 counter", flush_count, sat(exp_cnt));
      end
   endtask

   function automatic logic [AW-1:0] ladr(input int r, input int k);
      return 32'h0001_0000 + AW'((r * 4 + k) * 64) + 32'd8;
   endfunction

   task automatic pair_flush(input int r);
      int a, b;
      do_alloc(a); do_alloc(b);
      do_done(b, ladr(r, 1));
      do_snoop(ladr(r, 1));
      do_done(a, ladr(r, 0));
      do_retire(0, a, "R5 older retires");
      do_retire(1, b, "R6 flush on mark");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nerr++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin : main
      int idx [3];
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state
      chk(alloc_ready == 1, "R9 ready", alloc_ready, 1);
      chk(alloc_idx == 0, "R9 alloc_idx", alloc_idx, 0);
      chk(flush_count == 0, "R9 count", flush_count, 0);
      retire_req = 1; #1;
      chk(retire_grant == 0 && flush_valid == 0, "R9 empty retire", retire_grant, 0);
      @(negedge clk); retire_req = 0;

      // table of snoop scenarios (R3 R4 R5 R6 R7)
      for (int r = 0; r < 8; r++) begin
         logic [2:0] mask;
         int k;
         bit hitl, want;
         mask = ROWS[r][2:0]; k = int'(ROWS[r][4:3]);
         hitl = ROWS[r][5];   want = ROWS[r][6];
         for (int m = 0; m < 3; m++) do_alloc(idx[m]);
         for (int m = 0; m < 3; m++) if (mask[m]) do_done(idx[m], ladr(r, m));
         // offset 0x3C inside the line differs from the load's offset 8 (R3)
         do_snoop(hitl ? ((ladr(r, k) & ~32'h3F) | 32'h3C) : 32'hF000_0000);
         for (int m = 0; m < 3; m++) if (!mask[m]) do_done(idx[m], ladr(r, m));
         for (int m = 0; m < 3; m++) begin
            if (want && m == k) begin
               do_retire(1, idx[m], "R4 mark with older outstanding");
               break;
            end
            do_retire(0, idx[m], "R5 no effect retire");
         end
      end

      // R4: older load completing in the snoop cycle still counts as outstanding
      begin
         int a, b;
         do_alloc(a); do_alloc(b);
         do_done(b, 32'h0002_0040);
         done_valid = 1; done_idx = IW'(a); done_addr = 32'h0002_0000;
         snoop_valid = 1; snoop_addr = 32'h0002_0070;
         @(negedge clk);
         done_valid = 0; snoop_valid = 0;
         do_retire(0, a, "R4 same-cycle older retire");
         // R8: allocation refused in the flush cycle
         alloc_valid = 1;
         retire_req = 1; #1;
         chk(flush_valid == 1, "R4 same-cycle mark", flush_valid, 1);
         chk(alloc_ready == 0, "R8 no alloc in flush", alloc_ready, 0);
         chk(flush_idx == IW'(b), "R6 flush index", flush_idx, b);
         exp_cnt++; exp_tail = b;
         @(negedge clk);
         alloc_valid = 0; retire_req = 0;
         chk(alloc_idx == IW'(b), "R8 alloc not taken", alloc_idx, b);
      end

      // R10: completion for an unallocated slot is ignored
      t = exp_tail;
      do_done(t, 32'h0003_0000);
      do_alloc(idx[0]);
      retire_req = 1; #1;
      chk(retire_grant == 0, "R10 stale completion ignored", retire_grant, 0);
      chk(retire_grant == 0, "R2 no retire before data", retire_grant, 0);
      @(negedge clk); retire_req = 0;
      do_done(idx[0], 32'h0003_0000);
      do_retire(0, idx[0], "R2 retire after data");

      // R1: fill to DEPTH, refuse one more
      begin
         int slots [DEPTH];
         for (int m = 0; m < DEPTH; m++) do_alloc(slots[m]);
         alloc_valid = 1; #1;
         chk(alloc_ready == 0, "R1 full", alloc_ready, 0);
         @(negedge clk); alloc_valid = 0;
         chk(alloc_idx == IW'(exp_tail), "R1 full unchanged", alloc_idx, exp_tail);
         for (int m = 0; m < DEPTH; m++) do_done(slots[m], 32'h0004_0000 + AW'(m * 64));
         for (int m = 0; m < DEPTH; m++) do_retire(0, slots[m], "R1 drain");
         alloc_valid = 1; #1;
         chk(alloc_ready == 1, "R1 ready after drain", alloc_ready, 1);
         alloc_valid = 0;
      end

      // R7: saturate the counter
      while (exp_cnt < 9) pair_flush(20 + exp_cnt);
      chk(flush_count == 3'd7, "R7 saturated", flush_count, 7);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule